// File: doc/BRIEF.md
# Shared Multi-Queue Flit Buffer

This block is the storage stage of a router input port. A single pool of flit slots is shared by several virtual channels, and a slot is handed to whichever channel needs it at the moment it is needed. Each channel stays a strict first-in-first-out queue. Three tables make this work: a head pointer per channel, a tail pointer per channel, and a next-slot link per slot that chains a channel's slots in arrival order. Two state tables, one bit per slot and one bit per channel, record which slots hold data and which channels are non-empty.

Flits enter through a valid/ready stream that carries the flit and the number of the channel it belongs to. A transfer takes place on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low exactly when every slot is occupied. A sender must hold its flit and channel number stable while `in_valid` is high and `in_ready` is low. Flits leave through a per-channel read port. The consumer places a channel number on `rd_vc`, and the oldest flit of that channel appears combinationally on `rd_flit`, qualified by `rd_valid`. A dequeue takes place on a rising edge when `rd_valid` and `rd_ready` are both high. The consumer is normally the switch arbiter, which sits outside this block. An enqueue and a dequeue may both take place in the same cycle, whether they target the same channel or different channels.

Top module: `shared_vc_buffer`

## Requirements
- R1: While reset is active and on the first cycle after it, every channel reads as empty (`ch_empty` all ones), `rd_valid` is low for every `rd_vc`, `in_ready` is high and `buf_full` is low.
- R2: For each channel, flits are read out in exactly the order they were accepted for that channel, regardless of how traffic on other channels is interleaved.
- R3: When all slots are occupied, `in_ready` is low. A flit offered with `in_valid` high while `in_ready` is low is not stored and never appears on `rd_flit`.
- R4: `rd_valid` is high exactly when the channel selected by `rd_vc` holds at least one flit. While it is high, `rd_flit` shows that channel's oldest flit in the same cycle, with no register stage.
- R5: Holding `rd_ready` high while `rd_valid` is low removes nothing: the contents and order of every channel are unchanged.
- R6: Slots are not reserved per channel. A single channel can take all slots while the other channels are empty.
- R7: In one cycle, an enqueue and a dequeue both complete. This holds when they target different channels, and also when they target the same channel, including the case where that channel held exactly one flit.
- R8: `buf_full` is high exactly when the number of stored flits equals the slot count, and `in_ready` is always its complement.
- R9: Bit v of `ch_empty` is high exactly when channel v holds no flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming flit is offered |
| in_ready | output | 1 | Buffer can accept a flit this cycle |
| in_vc | input | VC_W (2) | Channel number of the incoming flit |
| in_flit | input | FLIT_W (32) | Incoming flit data |
| buf_full | output | 1 | Every slot is occupied |
| rd_vc | input | VC_W (2) | Channel selected for reading |
| rd_ready | input | 1 | Consumer takes the presented flit |
| rd_valid | output | 1 | Selected channel holds a flit |
| rd_flit | output | FLIT_W (32) | Oldest flit of the selected channel |
| ch_empty | output | VCS (4) | Per-channel empty flags |

## Verification
A corrupted link entry or head pointer shows up at the very next read of the affected channel: `rd_flit` presents a flit out of order, or a flit from a different channel. This is caught on the first dequeue of that channel after the fault. A stale slot state bit shows as the wrong capacity. `in_ready` then falls early, or stays high past a full buffer, on the cycle the pool reaches its limit. A stale channel state bit shows up at once on `ch_empty` and `rd_valid`. The bench therefore compares every read and every status pin against per-channel reference queues on every cycle. It drives the pool to full and back to empty several times, so that a slot leak builds up until it becomes visible.

// File: rtl/svb_pkg.sv
package svb_pkg;
  localparam int unsigned SVB_VCS    = 4;
  localparam int unsigned SVB_SLOTS  = 16;
  localparam int unsigned SVB_FLIT_W = 32;
endpackage

// File: rtl/svb_slot_alloc.sv
module svb_slot_alloc #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  input  logic [SW-1:0] give_slot,
  output logic [SW-1:0] pick_slot,
  output logic          any_free
);
  logic [SLOTS-1:0] busy;

  // one state bit per slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        busy[s] <= 1'b0;
      else if (take && pick_slot == SW'(s))
        busy[s] <= 1'b1;
      else if (give && give_slot == SW'(s))
        busy[s] <= 1'b0;
    end
  end

  // lowest-numbered free slot
  always_comb begin
    pick_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) pick_slot = SW'(i);
    end
  end

  assign any_free = ~&busy;
endmodule

// File: rtl/svb_flit_store.sv
module svb_flit_store #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned FLIT_W = 32,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [FLIT_W-1:0] wr_data,
  input  logic [SW-1:0]     rd_slot,
  output logic [FLIT_W-1:0] rd_data
);
  logic [FLIT_W-1:0] cells [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_slot] <= wr_data;
  end

  assign rd_data = cells[rd_slot];
endmodule

// File: rtl/svb_link_ctrl.sv
module svb_link_ctrl #(
  parameter int unsigned VCS   = 4,
  parameter int unsigned SLOTS = 16,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned VW = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq,
  input  logic [VW-1:0] enq_vc,
  input  logic [SW-1:0] enq_slot,
  input  logic          deq,
  input  logic [VW-1:0] sel_vc,
  output logic [SW-1:0] sel_head,
  output logic [VCS-1:0] vc_busy
);
  logic [SW-1:0] head [VCS];
  logic [SW-1:0] tail [VCS];
  logic [SW-1:0] link [SLOTS];

  logic same_vc, sel_single, enq_restart;

  assign sel_head    = head[sel_vc];
  assign same_vc     = deq && (sel_vc == enq_vc);
  assign sel_single  = (head[sel_vc] == tail[sel_vc]);
  assign enq_restart = !vc_busy[enq_vc] || (same_vc && sel_single);

  always_ff @(posedge clk) begin
    if (rst) begin
      vc_busy <= '0;
      for (int v = 0; v < VCS; v++) begin
        head[v] <= '0;
        tail[v] <= '0;
      end
      for (int s = 0; s < SLOTS; s++) link[s] <= '0;
    end else begin
      if (deq) begin
        head[sel_vc] <= link[head[sel_vc]];
        if (sel_single && !(enq && same_vc)) vc_busy[sel_vc] <= 1'b0;
      end
      if (enq) begin
        if (enq_restart)
          head[enq_vc] <= enq_slot;
        else
          link[tail[enq_vc]] <= enq_slot;
        tail[enq_vc]    <= enq_slot;
        vc_busy[enq_vc] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shared_vc_buffer.sv
module shared_vc_buffer
  import svb_pkg::*;
#(
  parameter int unsigned VCS    = SVB_VCS,
  parameter int unsigned SLOTS  = SVB_SLOTS,
  parameter int unsigned FLIT_W = SVB_FLIT_W,
  localparam int unsigned SW   = $clog2(SLOTS),
  localparam int unsigned VC_W = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              buf_full,
  input  logic [VC_W-1:0]   rd_vc,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [FLIT_W-1:0] rd_flit,
  output logic [VCS-1:0]    ch_empty
);
  logic          any_free;
  logic [SW-1:0] free_slot;
  logic [SW-1:0] head_slot;
  logic [VCS-1:0] vc_busy;
  logic          enq_fire, deq_fire;

  assign in_ready = any_free;
  assign buf_full = ~any_free;
  assign enq_fire = in_valid && any_free;
  assign rd_valid = vc_busy[rd_vc];
  assign deq_fire = rd_valid && rd_ready;
  assign ch_empty = ~vc_busy;

  svb_slot_alloc #(.SLOTS(SLOTS)) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .take      (enq_fire),
    .give      (deq_fire),
    .give_slot (head_slot),
    .pick_slot (free_slot),
    .any_free  (any_free)
  );

  svb_flit_store #(.SLOTS(SLOTS), .FLIT_W(FLIT_W)) u_store (
    .clk     (clk),
    .wr_en   (enq_fire),
    .wr_slot (free_slot),
    .wr_data (in_flit),
    .rd_slot (head_slot),
    .rd_data (rd_flit)
  );

  svb_link_ctrl #(.VCS(VCS), .SLOTS(SLOTS)) u_links (
    .clk      (clk),
    .rst      (rst),
    .enq      (enq_fire),
    .enq_vc   (in_vc),
    .enq_slot (free_slot),
    .deq      (deq_fire),
    .sel_vc   (rd_vc),
    .sel_head (head_slot),
    .vc_busy  (vc_busy)
  );
endmodule

// File: rtl/svb_checker.sv
module svb_checker #(
  parameter int unsigned VCS   = 4,
  parameter int unsigned SLOTS = 16,
  localparam int unsigned VC_W = (VCS > 1) ? $clog2(VCS) : 1,
  localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VC_W-1:0] in_vc,
  input logic            buf_full,
  input logic [VC_W-1:0] rd_vc,
  input logic            rd_ready,
  input logic            rd_valid,
  input logic [VCS-1:0]  ch_empty
);
  logic          rst_q;
  logic [CW-1:0] occ;
  logic [CW-1:0] cnt [VCS];
  logic          put, pull;

  assign put  = in_valid && in_ready;
  assign pull = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) occ <= '0;
    else occ <= occ + CW'(put) - CW'(pull);
  end

  for (genvar v = 0; v < VCS; v++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[v] <= '0;
      else cnt[v] <= cnt[v] + CW'(put && in_vc == VC_W'(v))
                            - CW'(pull && rd_vc == VC_W'(v));
    end
    assert_empty_flag_R9: assert property (@(posedge clk) disable iff (rst)
      ch_empty[v] == (cnt[v] == '0));
  end

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      assert_reset_state_R1: assert (&ch_empty && in_ready && !buf_full && !rd_valid);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(SLOTS)) |-> !in_ready);

  assert_full_count_R8: assert property (@(posedge clk) disable iff (rst)
    buf_full == (occ == CW'(SLOTS)));

  assert_ready_inverse_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready != buf_full);

  assert_valid_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (cnt[rd_vc] != '0));
endmodule

bind shared_vc_buffer svb_checker #(.VCS(VCS), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/tb_shared_vc_buffer.sv
module tb_shared_vc_buffer;
  localparam int NV = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_vc = '0;
  logic [31:0] in_flit = '0;
  logic        buf_full;
  logic [1:0]  rd_vc = '0;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_flit;
  logic [3:0]  ch_empty;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] mq [NV][NS];
  int          mn [NV];
  logic [31:0] tag = 32'h1000;

  always #10 clk = ~clk;

  shared_vc_buffer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vc(in_vc), .in_flit(in_flit), .buf_full(buf_full), .rd_vc(rd_vc),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_flit(rd_flit), .ch_empty(ch_empty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int stored();
    int t = 0;
    for (int v = 0; v < NV; v++) t += mn[v];
    return t;
  endfunction

  function automatic logic [3:0] exp_empty();
    logic [3:0] e;
    for (int v = 0; v < NV; v++) e[v] = (mn[v] == 0);
    return e;
  endfunction

  // one clock: offer optional enqueue and dequeue, check ports, update model
  task automatic step(input bit de, input int ev, input logic [31:0] ed, input bit dd, input int dv);
    bit ef, df;
    @(negedge clk);
    in_valid = de; in_vc = ev[1:0]; in_flit = ed;
    rd_ready = dd; rd_vc = dv[1:0];
    #1;
    chk(in_ready === (stored() < NS), "R3", {31'b0, in_ready}, {31'b0, stored() < NS});
    chk(buf_full === (stored() == NS), "R8", {31'b0, buf_full}, {31'b0, stored() == NS});
    chk(ch_empty === exp_empty(), "R9", {28'b0, ch_empty}, {28'b0, exp_empty()});
    chk(rd_valid === (mn[dv] > 0), "R4", {31'b0, rd_valid}, {31'b0, mn[dv] > 0});
    if (dd && mn[dv] > 0)
      chk(rd_flit === mq[dv][0], "R2", rd_flit, mq[dv][0]);
    ef = de && (stored() < NS);
    df = dd && (mn[dv] > 0);
    @(posedge clk);
    if (df) begin
      for (int i = 0; i < NS - 1; i++) mq[dv][i] = mq[dv][i+1];
      mn[dv]--;
    end
    if (ef) begin
      mq[ev][mn[ev]] = ed;
      mn[ev]++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; rd_ready = 1'b0;
  endtask

  task automatic push(input int v);
    tag++;
    step(1, v, tag, 0, 0);
  endtask

  task automatic pop(input int v);
    step(0, 0, 32'h0, 1, v);
  endtask

  task automatic drain_all();
    for (int v = 0; v < NV; v++)
      while (mn[v] > 0) pop(v);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ch_empty === 4'hf, "R1", {28'b0, ch_empty}, 32'hf);
    chk(in_ready === 1'b1 && buf_full === 1'b0, "R1", {30'b0, in_ready, buf_full}, 32'h2);
    for (int v = 0; v < NV; v++) begin
      rd_vc = v[1:0];
      #1;
      chk(rd_valid === 1'b0, "R1", {31'b0, rd_valid}, 32'h0);
    end
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) begin push(1); push(3); end
    for (int i = 0; i < 5; i++) pop(1);
    for (int i = 0; i < 5; i++) pop(3);
    idle();
    chk(ch_empty === 4'hf, "R2", {28'b0, ch_empty}, 32'hf);
  endtask

  task automatic t_fill_one();
    for (int i = 0; i < NS; i++) push(2);
    @(negedge clk); #1;
    chk(buf_full === 1'b1, "R6", {31'b0, buf_full}, 32'h1);
    // rejected offers while full
    step(1, 2, 32'hDEAD0001, 0, 0);
    step(1, 0, 32'hDEAD0002, 0, 0);
    idle(); #1;
    chk(ch_empty === 4'b1011, "R3", {28'b0, ch_empty}, 32'hb);
    drain_all();
  endtask

  task automatic t_empty_pull();
    push(0); push(0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 3);
    idle(); #1;
    chk(ch_empty === 4'b1110, "R5", {28'b0, ch_empty}, 32'he);
    drain_all();
  endtask

  task automatic t_simul();
    push(3);
    tag++; step(1, 0, tag, 1, 3);   // different channels
    idle(); #1;
    chk(ch_empty === 4'b0111 ? 1'b0 : ch_empty === 4'b1110, "R7", {28'b0, ch_empty}, 32'he);
    drain_all();
    push(1);
    tag++; step(1, 1, tag, 1, 1);   // same channel, single flit
    idle(); #1;
    chk(ch_empty === 4'b1101, "R7", {28'b0, ch_empty}, 32'hd);
    push(1);
    tag++; step(1, 1, tag, 1, 1);   // same channel, several flits
    drain_all();
  endtask

  task automatic t_random();
    int bias;
    for (int i = 0; i < 4000; i++) begin
      bias = ((i / 500) % 2 == 0) ? 75 : 30;
      tag++;
      step(($urandom % 100) < bias, $urandom % NV, tag, ($urandom % 100) < 100 - bias, $urandom % NV);
    end
    drain_all();
  endtask

  initial begin
    for (int v = 0; v < NV; v++) mn[v] = 0;
    void'($urandom(32'd11));
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_order();
    t_fill_one();
    t_empty_pull();
    t_simul();
    t_random();
    t_fill_one();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule